// File: doc/BRIEF.md
# Lowest-Priority CPU Interrupt Arbiter

This block decides which one of four processors takes an interrupt that is sent for dynamic delivery. Software loads a 4-bit task-priority value for each processor through a small write port. A request arrives as a one-cycle valid pulse together with a mask that says which processors may take it. The block picks the eligible processor whose task priority is numerically lowest. One cycle later it raises a grant strobe and drives a one-hot winner vector.

Processors that tie on the lowest task priority are separated by a private 4-bit arbitration counter for each processor. Among the tied processors, the one with the highest counter wins. Every granted delivery updates all counters on the edge that raises the grant. The winner's counter drops to 0 and every other counter goes up by one. A counter that is already at 15 does not wrap to 0. It is reloaded with the winner's counter value from before the delivery, plus one. As a result, processors that share a task priority take successive interrupts in turn.

Top module: `lowest_prio_arbiter`

## Requirements
- R1: After synchronous reset, grant is 0, the winner vector is all zeros, every task priority is 0, and CPU i's arbitration counter holds i.
- R2: A write with tp_wr_en high stores tp_wr_data as the task priority of CPU tp_wr_idx. The new value first affects requests presented in the cycle after the write. A request in the same cycle as the write sees the old value.
- R3: A request with req_valid high and a non-empty req_elig produces grant high in the next cycle. The winner is the eligible CPU with the numerically lowest task priority.
- R4: Among eligible CPUs that share the lowest task priority, the one with the largest arbitration counter wins. If the counters are also equal, the lowest CPU index wins.
- R5: On a granted delivery, the winner's arbitration counter becomes 0.
- R6: On a granted delivery, each non-winning CPU's counter increments by one when it was below 15. This applies whether or not that CPU was eligible.
- R7: On a granted delivery, a non-winning CPU whose counter was 15 is loaded with the winner's counter value from before the delivery, plus one (modulo 16).
- R8: A request with an empty eligibility mask, or a cycle without req_valid, gives grant 0 in the next cycle and leaves every arbitration counter unchanged.
- R9: When grant is high, win_onehot has exactly one bit set, and that bit was set in the eligibility mask of the request. When grant is low, win_onehot is all zeros.
- R10: Task-priority writes never change the arbitration counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_wr_en | input | 1 | Task-priority write strobe |
| tp_wr_idx | input | 2 | CPU index written |
| tp_wr_data | input | 4 | Task-priority value written |
| req_valid | input | 1 | Dynamic-delivery request strobe |
| req_elig | input | 4 | Eligible CPUs of the request, bit i = CPU i |
| grant | output | 1 | Delivery granted, one cycle after the request |
| win_onehot | output | 4 | One-hot winning CPU, valid with grant |

## Verification
The assertions check on every cycle that grant follows a valid, non-empty request with a one-cycle latency. They check that the winner vector is one-hot, lies inside the request's mask, and is zero without a grant. They also check that the counters hold still whenever no grant occurs, that the winner's counter clears to zero, and that each loser's counter either steps up by one or came from 15. The bench's scenarios are needed to show the rest. These are the lowest-task-priority choice, the tie-break by counter value and by index, the timing of a write against a request in the same cycle, and the reload to the winner's old value plus one. The bench shows these by running long single-CPU streaks that drive other counters to 15, and then checking the round-robin order that follows.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
    localparam int N_CPU = 4;
    localparam int TP_W  = 4;
    localparam int ARB_W = 4;
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    typedef logic [TP_W-1:0]  tp_t;
    typedef logic [ARB_W-1:0] arb_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [N_CPU-1:0] cpu_mask_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } pick_t;

    localparam arb_t ARB_MAX = {ARB_W{1'b1}};

    function automatic arb_t arb_reset_value(input int i);
        return arb_t'(i);
    endfunction

    // candidate a beats incumbent b: lower task priority, or equal and larger counter
    function automatic logic beats(input tp_t tp_a, input arb_t arb_a,
                                   input tp_t tp_b, input arb_t arb_b);
        return (tp_a < tp_b) || ((tp_a == tp_b) && (arb_a > arb_b));
    endfunction

    function automatic arb_t arb_next(input logic is_winner, input arb_t cur,
                                      input arb_t winner_old);
        if (is_winner)
            return '0;
        else if (cur == ARB_MAX)
            return arb_t'(winner_old + 1'b1);
        else
            return arb_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/lpa_tp_regs.sv
module lpa_tp_regs
    import lpa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  idx_t                   wr_idx,
    input  tp_t                    wr_data,
    output tp_t [N_CPU-1:0]        tp_q
);
    for (genvar i = 0; i < N_CPU; i++) begin : g_tp
        always_ff @(posedge clk) begin
            if (rst)
                tp_q[i] <= '0;
            else if (wr_en && (wr_idx == idx_t'(i)))
                tp_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/lpa_min_select.sv
module lpa_min_select
    import lpa_pkg::*;
(
    input  cpu_mask_t              elig,
    input  tp_t  [N_CPU-1:0]       tp_q,
    input  arb_t [N_CPU-1:0]       arb_q,
    output pick_t                  pick
);
    tp_t  best_tp;
    arb_t best_arb;

    always_comb begin
        pick     = '0;
        best_tp  = '0;
        best_arb = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (elig[i] && (!pick.hit || beats(tp_q[i], arb_q[i], best_tp, best_arb))) begin
                pick.hit = 1'b1;
                pick.idx = idx_t'(i);
                best_tp  = tp_q[i];
                best_arb = arb_q[i];
            end
        end
    end
endmodule

// File: rtl/lpa_arb_bank.sv
module lpa_arb_bank
    import lpa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  idx_t                   win_idx,
    output arb_t [N_CPU-1:0]       arb_q
);
    arb_t winner_old;
    assign winner_old = arb_q[win_idx];

    for (genvar i = 0; i < N_CPU; i++) begin : g_arb
        always_ff @(posedge clk) begin
            if (rst)
                arb_q[i] <= arb_reset_value(i);
            else if (upd)
                arb_q[i] <= arb_next(win_idx == idx_t'(i), arb_q[i], winner_old);
        end
    end
endmodule

// File: rtl/lowest_prio_arbiter.sv
module lowest_prio_arbiter
    import lpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tp_wr_en,
    input  logic [1:0] tp_wr_idx,
    input  logic [3:0] tp_wr_data,
    input  logic       req_valid,
    input  logic [3:0] req_elig,
    output logic       grant,
    output logic [3:0] win_onehot
);
    tp_t  [N_CPU-1:0] tp_q;
    arb_t [N_CPU-1:0] arb_q;
    pick_t            pick;
    logic             deliver;
    cpu_mask_t        pick_onehot;

    lpa_tp_regs u_tp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tp_wr_en),
        .wr_idx  (idx_t'(tp_wr_idx)),
        .wr_data (tp_t'(tp_wr_data)),
        .tp_q    (tp_q)
    );

    lpa_min_select u_sel (
        .elig  (cpu_mask_t'(req_elig)),
        .tp_q  (tp_q),
        .arb_q (arb_q),
        .pick  (pick)
    );

    assign deliver = req_valid && pick.hit;

    lpa_arb_bank u_arb (
        .clk     (clk),
        .rst     (rst),
        .upd     (deliver),
        .win_idx (pick.idx),
        .arb_q   (arb_q)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_dec
        assign pick_onehot[i] = (pick.idx == idx_t'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant      <= 1'b0;
            win_onehot <= '0;
        end else begin
            grant      <= deliver;
            win_onehot <= deliver ? pick_onehot : '0;
        end
    end
endmodule

// File: rtl/lpa_checker.sv
module lpa_checker
    import lpa_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [3:0]       req_elig,
    input logic             grant,
    input logic [3:0]       win_onehot,
    input arb_t [N_CPU-1:0] arb_q
);
    a_r3_grant_follows_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_elig != '0)) |=> grant);

    a_r8_no_grant_without_request: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && (req_elig != '0)) |=> !grant);

    a_r9_onehot_winner: assert property (@(posedge clk) disable iff (rst)
        grant |-> ($countones(win_onehot) == 1));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !grant |-> (win_onehot == '0));

    a_r9_winner_in_mask: assert property (@(posedge clk) disable iff (rst)
        grant |-> ((win_onehot & $past(req_elig)) == win_onehot));

    a_r8_counters_hold: assert property (@(posedge clk) disable iff (rst)
        !grant |-> $stable(arb_q));

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        a_r5_winner_cleared: assert property (@(posedge clk) disable iff (rst)
            (grant && win_onehot[i]) |-> (arb_q[i] == '0));

        a_r6_loser_steps: assert property (@(posedge clk) disable iff (rst)
            (grant && !win_onehot[i]) |->
                ((arb_q[i] == arb_t'($past(arb_q[i]) + 1'b1)) || ($past(arb_q[i]) == ARB_MAX)));
    end
endmodule

bind lowest_prio_arbiter lpa_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_elig   (req_elig),
    .grant      (grant),
    .win_onehot (win_onehot),
    .arb_q      (arb_q)
);

// File: tb/sim_lowest_prio_arbiter.sv
module sim_lowest_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic       tp_wr_en;
    logic [1:0] tp_wr_idx;
    logic [3:0] tp_wr_data;
    logic       req_valid;
    logic [3:0] req_elig;
    logic       grant;
    logic [3:0] win_onehot;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_tp  [4];
    int m_arb [4];

    always #10 clk = ~clk;

    lowest_prio_arbiter u0 (
        .clk(clk), .rst(rst), .tp_wr_en(tp_wr_en), .tp_wr_idx(tp_wr_idx),
        .tp_wr_data(tp_wr_data), .req_valid(req_valid), .req_elig(req_elig),
        .grant(grant), .win_onehot(win_onehot)
    );

    function automatic int model_pick(input logic [3:0] elig);
        int w = -1;
        for (int i = 0; i < 4; i++)
            if (elig[i] && (w < 0 || m_tp[i] < m_tp[w] ||
                            (m_tp[i] == m_tp[w] && m_arb[i] > m_arb[w])))
                w = i;
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check outputs at following negedge
    task automatic step(input bit we, input int widx, input int wdata,
                        input bit v, input logic [3:0] elig, input string req);
        int w;
        int wold;
        tp_wr_en = we; tp_wr_idx = 2'(widx); tp_wr_data = 4'(wdata);
        req_valid = v; req_elig = elig;
        w = v ? model_pick(elig) : -1;
        @(posedge clk);
        if (w >= 0) begin
            wold = m_arb[w];
            for (int i = 0; i < 4; i++)
                if (i == w) m_arb[i] = 0;
                else if (m_arb[i] == 15) m_arb[i] = (wold + 1) % 16;
                else m_arb[i] = m_arb[i] + 1;
        end
        if (we) m_tp[widx] = wdata;
        @(negedge clk);
        check(req, int'(grant), (w >= 0) ? 1 : 0);
        check(req, int'(win_onehot), (w >= 0) ? (1 << w) : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; tp_wr_en = 0; tp_wr_idx = 0; tp_wr_data = 0;
        req_valid = 0; req_elig = 0;
        for (int i = 0; i < 4; i++) begin m_tp[i] = 0; m_arb[i] = i; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 grant", int'(grant), 0);
        check("R1 onehot", int'(win_onehot), 0);
        rst = 1'b0;

        // R1/R4: reset counters make CPU3 win a full tie, then rotate
        step(0, 0, 0, 1, 4'b1111, "R4 tie reset order");
        step(0, 0, 0, 1, 4'b1111, "R4 rotate");
        step(0, 0, 0, 1, 4'b1111, "R4 rotate");
        // R8: empty mask and idle cycles leave counters alone
        step(0, 0, 0, 1, 4'b0000, "R8 empty mask");
        step(0, 0, 0, 0, 4'b1111, "R8 no valid");
        step(0, 0, 0, 1, 4'b1111, "R8 counters unchanged");
        // R2/R3: lowest task priority wins; write same cycle as request sees old value
        step(1, 0, 9, 0, 4'b0000, "R2 write");
        step(1, 1, 9, 0, 4'b0000, "R2 write");
        step(1, 2, 9, 0, 4'b0000, "R2 write");
        step(1, 3, 2, 1, 4'b1111, "R2 same-cycle old value");
        step(0, 0, 0, 1, 4'b1111, "R3 lowest task priority");
        step(0, 0, 0, 1, 4'b0111, "R3 ineligible low excluded");
        // R10: writes alone do not disturb counters
        step(1, 3, 9, 0, 4'b0000, "R10 write");
        step(1, 3, 9, 0, 4'b0000, "R10 write");
        step(0, 0, 0, 1, 4'b1111, "R10 tie after writes");
        // R6/R7: streak to CPU0 drives others to 15 and beyond
        for (int k = 0; k < 20; k++)
            step(0, 0, 0, 1, 4'b0001, "R6 streak");
        for (int k = 0; k < 8; k++)
            step(0, 0, 0, 1, 4'b1111, "R7 after wrap");
        for (int k = 0; k < 20; k++)
            step(0, 0, 0, 1, 4'b0100, "R7 streak");
        for (int k = 0; k < 8; k++)
            step(0, 0, 0, 1, 4'b1110, "R5 R7 tie order");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            bit  we = ($urandom % 4) == 0;
            bit  v  = ($urandom % 5) != 0;
            int  tv = ($urandom % 3 == 0) ? int'($urandom % 16) : 5;
            step(we, int'($urandom % 4), tv, v, 4'($urandom), "R3 R4 R6 R7 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule